// File: doc/BRIEF.md
# Packet Buffer Pointer and Data Port

This block is the host's window into on-chip packet memory. The memory holds a transmit area and a receive area. The host first writes a 16-bit pointer word. That word holds a byte offset inside a packet and three control bits. The first control bit chooses the receive or the transmit area. The second turns auto-increment on or off. The third sets the direction of the accesses that follow. After that, the host moves data through a data port that is one, two or four bytes wide, and each transfer uses a simple request/acknowledge handshake.

For reads, the block fetches four bytes from memory ahead of time and holds them in a small prefetch buffer. It raises a ready flag once those bytes are available. For writes, host data goes into a short write queue, which drains into memory one entry per cycle. While anything in that queue is still uncommitted, a status bit in the pointer readback stays set. Packet memory is built from four byte-wide synchronous RAMs, one per byte lane, so a four-byte transfer may start at any byte offset.

Top module: `pkt_ptr_port`

## Requirements
- R1: The pointer readback word has these fields:
  - bits [10:0]: the byte offset
  - bit 11: the not-empty status, which is read-only
  - bit 12: a reserved bit that always reads 0
  - bit 13: the read-direction bit
  - bit 14: the auto-increment bit
  - bit 15: the receive-select bit
- R2: A pointer write with only the low byte enabled (ptrWrBe = 01) changes nothing that can be seen. A later write with the high byte enabled applies the new high byte together with the staged low byte, and starts any prefetch.
- R3: When auto-increment is on, each completed data transfer moves the offset forward by the transfer size. dataSize 0 steps by 1, 1 steps by 2, and 2 or 3 step by 4.
- R4: The offset in the readback is the address of the most recent completed data transfer. If no transfer has completed since the pointer was loaded, it is the loaded offset. Prefetches never change it.
- R5: A pointer load with the read bit set drops dataRdy in the next cycle. dataAck stays low for a read request while dataRdy is low, so a read waits for fresh prefetch data.
- R6: In write mode, an accepted transfer sets the not-empty bit in the next cycle. The bit clears once the queue has committed every entry to memory.
- R7: When receive-select is 1, memory accesses use rxPktNum as the packet number. When it is 0, they use txPktNum.
- R8: When the read bit is 1, dataReq performs a read and leaves memory unchanged. When the read bit is 0, dataReq performs a write.
- R9: When auto-increment is off, the two low offset bits are ignored. Transfers use the dword-aligned address and do not move the offset.
- R10: Byte k of dataWrData and dataRdData corresponds to offset+k, little-endian, for any starting offset. Read bytes beyond the transfer size return 0.
- R11: A prefetch waits until the write queue is empty. A read that follows a write therefore returns the written data, even when the pointer is reloaded in the same cycle as the last write.
- R12: After reset, the pointer readback is 0 and dataRdy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWrEn | input | 1 | Pointer write strobe |
| ptrWrBe | input | 2 | Pointer write byte enables: bit 0 for the low byte, bit 1 for the high byte |
| ptrWrData | input | 16 | Pointer write value |
| ptrRdData | output | 16 | Pointer readback |
| txPktNum | input | 1 | Packet number for transmit-area accesses |
| rxPktNum | input | 1 | Packet number at the head of the receive-done queue |
| dataReq | input | 1 | Data transfer request |
| dataSize | input | 2 | Transfer size: 0 byte, 1 word, 2 or 3 dword |
| dataWrData | input | 32 | Write data, little-endian |
| dataRdData | output | 32 | Read data, little-endian, with unused bytes set to zero |
| dataAck | output | 1 | The transfer completes at this clock edge |
| dataRdy | output | 1 | Prefetched read data is valid |

## Verification
The data port is driven with byte, word and dword transfers at aligned and unaligned offsets. This shows whether lane steering and the size-dependent step are correct, rather than merely consistent with each other. The same offsets are read from the transmit area and the receive area, which separates the two packet-number sources. Runs with auto-increment off show that the low offset bits are ignored and that the offset does not move. Pointer loads are issued as split byte writes, as reads made immediately after the load (these must stall), and as a load in the same cycle as a queued write (the read that follows must see the new data).

// File: rtl/pkt_ptr_pkg.sv
`timescale 1ns/1ps
package pkt_ptr_pkg;
  localparam int OFS_W  = 11;           // byte offset width inside a packet
  localparam int PKT_W  = 1;            // packet number width
  localparam int PTR_W  = 16;           // pointer word width
  localparam int DATA_W = 32;           // data port width
  localparam int LANES  = DATA_W / 8;   // byte lanes
  localparam int WORD_W = OFS_W - 2;    // dword index width inside a packet

  // Pointer field positions (software decodes these)
  localparam int BIT_NE  = 11;
  localparam int BIT_RSV = 12;
  localparam int BIT_RD  = 13;
  localparam int BIT_AI  = 14;
  localparam int BIT_RCV = 15;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             fetch;   // issue a 4-byte prefetch this cycle
    logic             push;    // push a host write into the queue
    logic [PKT_W-1:0] pkt;     // packet number of the access
    logic [OFS_W-1:0] addr;    // effective byte offset of the access
    logic [1:0]       size;    // transfer size code
  } strobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pkt_ptr_lane_ram.sv
`timescale 1ns/1ps
module pkt_ptr_lane_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port; rdata only updates on a read, so it holds between fetches
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/pkt_ptr_ctrl.sv
`timescale 1ns/1ps
module pkt_ptr_ctrl
  import pkt_ptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ptrWrEn,
  input  logic [1:0]       ptrWrBe,
  input  logic [PTR_W-1:0] ptrWrData,
  output logic [PTR_W-1:0] ptrRdData,
  input  logic [PKT_W-1:0] txPktNum,
  input  logic [PKT_W-1:0] rxPktNum,
  input  logic             dataReq,
  input  logic [1:0]       dataSize,
  output logic             dataAck,
  output logic             dataRdy,
  input  logic             wfEmpty,
  input  logic             wfFull,
  output strobe_t          strb
);
  logic [7:0]       lowStage;
  logic             rcvBit, aiBit, rdBit;
  logic [OFS_W-1:0] curOfs;     // next address to be accessed
  logic [OFS_W-1:0] showOfs;    // last address the host accessed
  logic             fetchPend, bufValid;

  logic             loadNow;
  logic [PTR_W-1:0] newPtr;
  logic [OFS_W-1:0] effOfs, stepOfs;
  logic             rdAck, wrAck, doFetch;
  logic             unusedWrBits;

  assign loadNow = ptrWrEn & ptrWrBe[1];
  assign newPtr  = {ptrWrData[PTR_W-1:8], (ptrWrBe[0] ? ptrWrData[7:0] : lowStage)};
  assign unusedWrBits = ^{ptrWrData[BIT_RSV], ptrWrData[BIT_NE]};

  assign effOfs  = aiBit ? curOfs : {curOfs[OFS_W-1:2], 2'b00};
  assign stepOfs = curOfs + OFS_W'(sizeBytes(dataSize));

  assign rdAck   = dataReq &  rdBit & bufValid;
  assign wrAck   = dataReq & ~rdBit & ~wfFull;
  assign doFetch = fetchPend & wfEmpty & ~loadNow;

  assign dataAck = rdAck | wrAck;
  assign dataRdy = rdBit & bufValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowStage  <= '0;
      rcvBit    <= 1'b0;
      aiBit     <= 1'b0;
      rdBit     <= 1'b0;
      curOfs    <= '0;
      showOfs   <= '0;
      fetchPend <= 1'b0;
      bufValid  <= 1'b0;
    end else begin
      if (ptrWrEn && ptrWrBe[0] && !ptrWrBe[1]) lowStage <= ptrWrData[7:0];
      if (loadNow) begin
        curOfs    <= newPtr[OFS_W-1:0];
        showOfs   <= newPtr[OFS_W-1:0];
        rdBit     <= newPtr[BIT_RD];
        aiBit     <= newPtr[BIT_AI];
        rcvBit    <= newPtr[BIT_RCV];
        fetchPend <= newPtr[BIT_RD];
        bufValid  <= 1'b0;
      end else begin
        if (doFetch) begin
          fetchPend <= 1'b0;
          bufValid  <= 1'b1;
        end
        if (rdAck || wrAck) begin
          showOfs <= effOfs;
          if (aiBit) curOfs <= stepOfs;
          if (rdAck && aiBit) begin
            bufValid  <= 1'b0;
            fetchPend <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.fetch = doFetch;
    strb.push  = wrAck;
    strb.pkt   = rcvBit ? rxPktNum : txPktNum;
    strb.addr  = effOfs;
    strb.size  = dataSize;
  end

  assign ptrRdData = {rcvBit, aiBit, rdBit, 1'b0, ~wfEmpty, showOfs};
endmodule

// File: rtl/pkt_ptr_dpath.sv
`timescale 1ns/1ps
module pkt_ptr_dpath
  import pkt_ptr_pkg::*;
#(
  parameter int WF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dataWrData,
  input  logic [1:0]        dataSize,
  output logic [DATA_W-1:0] dataRdData,
  output logic              wfEmpty,
  output logic              wfFull
);
  localparam int CNT_W  = $clog2(WF_DEPTH + 1);
  localparam int IDX_W  = (WF_DEPTH > 1) ? $clog2(WF_DEPTH) : 1;
  localparam int RAM_AW = PKT_W + WORD_W;

  typedef struct packed {
    logic [PKT_W-1:0]  pkt;
    logic [OFS_W-1:0]  addr;
    logic [1:0]        size;
    logic [DATA_W-1:0] data;
  } wentry_t;

  wentry_t          fifoMem [WF_DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [CNT_W-1:0] count;
  wentry_t          head;
  logic             drain;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(WF_DEPTH - 1)) ? '0 : i + IDX_W'(1);
  endfunction

  assign head    = fifoMem[rdIdx];
  assign wfEmpty = (count == '0);
  assign wfFull  = (count == CNT_W'(WF_DEPTH));
  assign drain   = ~wfEmpty;

  always_ff @(posedge clk) begin
    if (strb.push) fifoMem[wrIdx] <= {strb.pkt, strb.addr, strb.size, dataWrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrIdx <= nextIdx(wrIdx);
      if (drain)     rdIdx <= nextIdx(rdIdx);
      if (strb.push && !drain)      count <= count + CNT_W'(1);
      else if (!strb.push && drain) count <= count - CNT_W'(1);
    end
  end

  // The queue drains with priority; a fetch is only issued when it is empty
  logic [PKT_W-1:0] selPkt;
  logic [OFS_W-1:0] selAddr;
  logic [2:0]       selBytes;

  assign selPkt   = drain ? head.pkt  : strb.pkt;
  assign selAddr  = drain ? head.addr : strb.addr;
  assign selBytes = sizeBytes(head.size);

  logic [1:0] qAlign;
  always_ff @(posedge clk) begin
    if (!rstN)           qAlign <= '0;
    else if (strb.fetch) qAlign <= strb.addr[1:0];
  end

  logic [7:0] laneQ [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0]        k;
    logic [WORD_W-1:0] wordIdx;
    logic              laneWe;
    logic [7:0]        laneD;

    assign k       = 2'(i) - selAddr[1:0];
    assign wordIdx = selAddr[OFS_W-1:2] + WORD_W'(2'(i) < selAddr[1:0]);
    assign laneWe  = drain & ({1'b0, k} < selBytes);
    assign laneD   = head.data[{k, 3'b000} +: 8];

    pkt_ptr_lane_ram #(.AW(RAM_AW), .DW(8)) u_ram (
      .clk   (clk),
      .en    (strb.fetch | laneWe),
      .we    (laneWe),
      .addr  ({selPkt, wordIdx}),
      .wdata (laneD),
      .rdata (laneQ[i])
    );
  end

  for (genvar b = 0; b < LANES; b++) begin : g_rd
    logic [1:0] ln;
    assign ln = qAlign + 2'(b);
    assign dataRdData[8*b +: 8] = (3'(b) < sizeBytes(dataSize)) ? laneQ[ln] : 8'h00;
  end
endmodule

// File: rtl/pkt_ptr_port.sv
`timescale 1ns/1ps
module pkt_ptr_port
  import pkt_ptr_pkg::*;
#(
  parameter int WF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrWrEn,
  input  logic [1:0]        ptrWrBe,
  input  logic [PTR_W-1:0]  ptrWrData,
  output logic [PTR_W-1:0]  ptrRdData,
  input  logic [PKT_W-1:0]  txPktNum,
  input  logic [PKT_W-1:0]  rxPktNum,
  input  logic              dataReq,
  input  logic [1:0]        dataSize,
  input  logic [DATA_W-1:0] dataWrData,
  output logic [DATA_W-1:0] dataRdData,
  output logic              dataAck,
  output logic              dataRdy
);
  strobe_t strb;
  logic    wfEmpty, wfFull;

  pkt_ptr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ptrWrEn   (ptrWrEn),
    .ptrWrBe   (ptrWrBe),
    .ptrWrData (ptrWrData),
    .ptrRdData (ptrRdData),
    .txPktNum  (txPktNum),
    .rxPktNum  (rxPktNum),
    .dataReq   (dataReq),
    .dataSize  (dataSize),
    .dataAck   (dataAck),
    .dataRdy   (dataRdy),
    .wfEmpty   (wfEmpty),
    .wfFull    (wfFull),
    .strb      (strb)
  );

  pkt_ptr_dpath #(.WF_DEPTH(WF_DEPTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataWrData (dataWrData),
    .dataSize   (dataSize),
    .dataRdData (dataRdData),
    .wfEmpty    (wfEmpty),
    .wfFull     (wfFull)
  );
endmodule

// File: rtl/pkt_ptr_port_chk.sv
`timescale 1ns/1ps
module pkt_ptr_port_chk
  import pkt_ptr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             ptrWrEn,
  input logic [1:0]       ptrWrBe,
  input logic [PTR_W-1:0] ptrWrData,
  input logic [PTR_W-1:0] ptrRdData,
  input logic             dataReq,
  input logic             dataAck,
  input logic             dataRdy
);
  logic unusedChkBits;
  assign unusedChkBits = ^{ptrWrData[PTR_W-1:BIT_RD+1], ptrWrData[BIT_RD-1:0]};

  // R5: loading a read pointer invalidates the prefetch buffer
  a_r5_load_drops_rdy: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrEn && ptrWrBe[1] && ptrWrData[BIT_RD]) |=> !dataRdy);

  // R5: no read completes without valid prefetch data
  a_r5_read_waits_rdy: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && ptrRdData[BIT_RD] && !dataRdy) |-> !dataAck);

  // R2: a low-byte-only pointer write has no visible effect
  a_r2_low_byte_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrEn && ptrWrBe == 2'b01 && !dataReq)
      |=> ($stable(ptrRdData[PTR_W-1:BIT_RSV]) && $stable(ptrRdData[OFS_W-1:0])));

  // R6: an accepted write leaves data pending in the queue
  a_r6_push_sets_ne: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && dataAck && !ptrRdData[BIT_RD] && !ptrWrEn) |=> ptrRdData[BIT_NE]);

  // R4: without host activity the reported offset holds
  a_r4_idle_offset_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReq && !ptrWrEn) |=> $stable(ptrRdData[OFS_W-1:0]));

  // R3: an auto-incrementing read triggers a new prefetch
  a_r3_autoinc_refetch: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && dataAck && ptrRdData[BIT_RD] && ptrRdData[BIT_AI] && !ptrWrEn) |=> !dataRdy);
endmodule

bind pkt_ptr_port pkt_ptr_port_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ptrWrEn   (ptrWrEn),
  .ptrWrBe   (ptrWrBe),
  .ptrWrData (ptrWrData),
  .ptrRdData (ptrRdData),
  .dataReq   (dataReq),
  .dataAck   (dataAck),
  .dataRdy   (dataRdy)
);

// File: tb/pkt_ptr_port_test.sv
`timescale 1ns/1ps
module pkt_ptr_port_test;
  localparam logic [15:0] RD  = 16'h2000;
  localparam logic [15:0] AI  = 16'h4000;
  localparam logic [15:0] RCV = 16'h8000;
  localparam logic [15:0] NE  = 16'h0800;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ptrWrEn;
  logic [1:0]  ptrWrBe;
  logic [15:0] ptrWrData;
  logic [15:0] ptrRdData;
  logic [0:0]  txPktNum, rxPktNum;
  logic        dataReq;
  logic [1:0]  dataSize;
  logic [31:0] dataWrData;
  logic [31:0] dataRdData;
  logic        dataAck, dataRdy;

  always #2.5 clk = ~clk;

  pkt_ptr_port uut (
    .clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .ptrWrBe(ptrWrBe),
    .ptrWrData(ptrWrData), .ptrRdData(ptrRdData), .txPktNum(txPktNum),
    .rxPktNum(rxPktNum), .dataReq(dataReq), .dataSize(dataSize),
    .dataWrData(dataWrData), .dataRdData(dataRdData), .dataAck(dataAck),
    .dataRdy(dataRdy)
  );

  int nRun  = 0;
  int nFail = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: each completing read pops one expected item
  initial forever begin
    @(negedge clk);
    #1;
    if (dataReq && dataAck && ptrRdData[13]) begin
      if (expQ.size() == 0) check("R10 unexpected read", dataRdData, 32'h0);
      else check(tagQ.pop_front(), dataRdData, expQ.pop_front());
    end
  end

  task automatic ptrLoad(input logic [15:0] w);
    @(negedge clk);
    ptrWrEn = 1'b1; ptrWrBe = 2'b11; ptrWrData = w;
    @(negedge clk);
    ptrWrEn = 1'b0;
  endtask

  task automatic ptrByte(input logic [1:0] be, input logic [15:0] w);
    @(negedge clk);
    ptrWrEn = 1'b1; ptrWrBe = be; ptrWrData = w;
    @(negedge clk);
    ptrWrEn = 1'b0;
  endtask

  task automatic access(input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    dataReq = 1'b1; dataSize = sz; dataWrData = wd;
    #1;
    while (!dataAck) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    dataReq = 1'b0; dataWrData = '1;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    access(sz, 32'hFFFF_FFFF);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; ptrWrEn = 1'b0; ptrWrBe = 2'b00; ptrWrData = '0;
    txPktNum = 1'b0; rxPktNum = 1'b1;
    dataReq = 1'b0; dataSize = 2'd0; dataWrData = '1;
    repeat (3) @(negedge clk);
    check("R12 reset pointer", {16'h0, ptrRdData}, 32'h0);
    check("R12 reset rdy", {31'h0, dataRdy}, 32'h0);
    rstN = 1'b1;

    // Fill transmit packet bytes 0x10..0x17 (R8 write mode, R3 steps)
    ptrLoad(AI | 16'h010);
    check("R1 pointer layout", {16'h0, ptrRdData}, {16'h0, AI | 16'h010});
    access(2'd2, 32'h4433_2211);
    check("R6 not-empty after push, R4 offset", {16'h0, ptrRdData}, {16'h0, AI | NE | 16'h010});
    @(negedge clk);
    check("R6 not-empty clears", {16'h0, ptrRdData}, {16'h0, AI | 16'h010});
    access(2'd0, 32'h0000_0055);
    check("R3 dword step", {16'h0, ptrRdData & ~NE}, {16'h0, AI | 16'h014});
    access(2'd1, 32'h0000_7766);
    check("R3 byte step", {16'h0, ptrRdData & ~NE}, {16'h0, AI | 16'h015});
    access(2'd0, 32'h0000_0088);
    check("R3 word step", {16'h0, ptrRdData & ~NE}, {16'h0, AI | 16'h017});

    // Receive packet, same offset
    ptrLoad(RCV | AI | 16'h010);
    access(2'd2, 32'hDEAD_BEEF);

    // Read back transmit packet
    ptrLoad(RD | AI | 16'h010);
    check("R5 rdy low after load", {31'h0, dataRdy}, 32'h0);
    check("R4 loaded offset", {16'h0, ptrRdData}, {16'h0, RD | AI | 16'h010});
    rd(2'd2, 32'h4433_2211, "R10 dword read");
    rd(2'd0, 32'h0000_0055, "R10 byte read upper zero");
    rd(2'd1, 32'h0000_7766, "R3 word read");
    rd(2'd0, 32'h0000_0088, "R3 byte read");
    check("R4 last accessed offset", {16'h0, ptrRdData}, {16'h0, RD | AI | 16'h017});

    ptrLoad(RD | AI | 16'h012);
    rd(2'd2, 32'h6655_4433, "R10 unaligned dword");

    ptrLoad(RCV | RD | AI | 16'h010);
    rd(2'd2, 32'hDEAD_BEEF, "R7 receive packet");
    check("R7 pointer", {16'h0, ptrRdData}, {16'h0, RCV | RD | AI | 16'h010});

    // Auto-increment off
    ptrLoad(RD | 16'h013);
    check("R4 loaded unaligned", {16'h0, ptrRdData}, {16'h0, RD | 16'h013});
    rd(2'd2, 32'h4433_2211, "R9 aligned access, R8 reads left memory intact");
    check("R9 aligned offset", {16'h0, ptrRdData}, {16'h0, RD | 16'h010});
    rd(2'd2, 32'h4433_2211, "R9 no step");
    check("R9 offset holds", {16'h0, ptrRdData}, {16'h0, RD | 16'h010});

    // Byte-wise pointer load
    ptrByte(2'b01, 16'h0014);
    check("R2 low byte no effect", {16'h0, ptrRdData}, {16'h0, RD | 16'h010});
    ptrByte(2'b10, 16'h6000);
    check("R2 high byte commits", {16'h0, ptrRdData}, {16'h0, RD | AI | 16'h014});
    rd(2'd0, 32'h0000_0055, "R2 prefetch after high byte");

    // Read issued right after load stalls
    ptrLoad(RD | AI | 16'h015);
    dataReq = 1'b1; dataSize = 2'd1;
    #1;
    check("R5 read stalls", {31'h0, dataAck}, 32'h0);
    check("R5 rdy low", {31'h0, dataRdy}, 32'h0);
    @(negedge clk);
    dataReq = 1'b0;
    rd(2'd1, 32'h0000_7766, "R5 read after stall");
    check("R5 pointer after read", {16'h0, ptrRdData}, {16'h0, RD | AI | 16'h015});

    // Reload in the same cycle as a queued write
    ptrLoad(AI | 16'h020);
    @(negedge clk);
    dataReq = 1'b1; dataSize = 2'd2; dataWrData = 32'hCAFE_F00D;
    ptrWrEn = 1'b1; ptrWrBe = 2'b11; ptrWrData = RD | AI | 16'h020;
    #1;
    check("R11 write accepted", {31'h0, dataAck}, 32'h1);
    @(negedge clk);
    dataReq = 1'b0; ptrWrEn = 1'b0; dataWrData = '1;
    check("R11 pending write", {16'h0, ptrRdData}, {16'h0, RD | AI | NE | 16'h020});
    rd(2'd2, 32'hCAFE_F00D, "R11 read sees write");

    repeat (4) @(negedge clk);
    check("R10 scoreboard drained", expQ.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule